// File: doc/BRIEF.md
# Configurable Routing Crossbar (Four Sources, Two Sinks)

This block is a small programmable interconnect point. Four routing wires enter it and two leave it. Each outgoing wire is driven by its own 4:1 multiplexer, and that multiplexer can pick any of the four incoming wires. The routing choice is not a port. It is held in configuration bits inside the block, two bits per output and four in total.

The four configuration bits form one segment of a serial configuration chain that runs through the whole device. A loader shifts a bit stream into `cfgIn` on rising edges of `cfgClk` while `shiftEn` is high. Bits leave through `cfgOut` toward the next segment of the chain. Once loading is finished, the block routes purely combinationally: no clock lies between `routeIn` and `routeOut`. The stored selection holds for as long as no shift occurs.

Top module: `sm_switch_matrix`

## Requirements
- R1: Each output `routeOut[k]` equals `routeIn[s_k]`, where `s_k` is that output's stored 2-bit select. The output follows changes on `routeIn` with no clock edge in between.
- R2: While `rstN` is low, all four configuration bits are zero and the chain's serial output `cfgOut` is 0. Reset takes effect without a clock edge, so both outputs carry `routeIn[0]`.
- R3: At a rising edge of `cfgClk` with `shiftEn` high, the chain moves one place. The value on `cfgIn` enters configuration bit 3, and every other bit moves one place toward bit 0.
- R4: At a rising edge of `cfgClk` with `shiftEn` low, the configuration does not change. Activity on `cfgIn` then has no effect on the routing.
- R5: Select encoding is binary: select value n routes `routeIn[n]`. Output 0 takes its select from configuration bits 1:0, and output 1 takes its select from bits 3:2. After four shifts of b0, b1, b2, b3 (b0 first), output 0's select is {b1,b0} and output 1's select is {b3,b2}.
- R6: Both outputs may hold the same select value, and then both carry the same input.
- R7: `cfgOut` always shows configuration bit 0. The bits therefore leave the segment in the order they entered, four shifts later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfgClk | input | 1 | Configuration clock for the serial chain |
| rstN | input | 1 | Asynchronous active-low reset; clears the configuration |
| shiftEn | input | 1 | Shift enable for the chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out (configuration bit 0) |
| routeIn | input | 4 | Routing input wires |
| routeOut | output | 2 | Routing output wires |

## Verification
The bench loads every select value into each output and then drives all sixteen input patterns through the routing. A bit-order or slice mix-up in the chain would send an output to the wrong wire or swap the two outputs' selects. It also loads the same select into both outputs, which catches a design that keeps the outputs exclusive. It toggles `cfgIn` with the shift enable low, so a chain that shifts regardless of the enable would corrupt the routing. It also reads the stream back through `cfgOut`, where a reversed or lagging chain shows up as a wrong bit sequence. Finally, it asserts reset in the middle of operation with no clock edge, so a synchronous or missing clear leaves the old routing in place.

// File: rtl/sm_pkg.sv
package sm_pkg;
  // Strobes from the top-level scan port into the configuration store
  typedef struct packed {
    logic shift;
    logic bitIn;
  } scanStrobe_t;
endpackage

// File: rtl/sm_cfg_chain.sv
module sm_cfg_chain #(
  parameter int CFG_BITS = 4
) (
  input  logic                    cfgClk,
  input  logic                    rstN,
  input  sm_pkg::scanStrobe_t     strobe,
  output logic [CFG_BITS-1:0]     cfgBits,
  output logic                    cfgOut
);

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN)
      cfgBits <= '0;
    else if (strobe.shift)
      cfgBits <= {strobe.bitIn, cfgBits[CFG_BITS-1:1]};
  end

  assign cfgOut = cfgBits[0];

  // R2: configuration is clear whenever reset is held
  a_r2_clear_in_reset: assert property (@(posedge cfgClk)
    !rstN |-> (cfgBits == '0));

  // R4: no shift strobe, no configuration change
  a_r4_hold_when_idle: assert property (@(posedge cfgClk) disable iff (!rstN)
    !strobe.shift |=> $stable(cfgBits));

  // R3: serial input lands at the head of the chain
  a_r3_head_enters: assert property (@(posedge cfgClk) disable iff (!rstN)
    strobe.shift |=> (cfgBits[CFG_BITS-1] == $past(strobe.bitIn)));

  // R7: the serial output advances by one place per shift
  a_r7_scan_advances: assert property (@(posedge cfgClk) disable iff (!rstN)
    strobe.shift |=> (cfgOut == $past(cfgBits[1])));

endmodule

// File: rtl/sm_route.sv
module sm_route #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 2,
  localparam int SEL_W  = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0]        routeIn,
  input  logic [NUM_OUT*SEL_W-1:0] selBus,
  output logic [NUM_OUT-1:0]       routeOut
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_outMux
    logic [SEL_W-1:0] selK;
    assign selK        = selBus[k*SEL_W +: SEL_W];
    assign routeOut[k] = routeIn[selK];
  end

endmodule

// File: rtl/sm_switch_matrix.sv
module sm_switch_matrix #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 2,
  localparam int SEL_W    = $clog2(NUM_IN),
  localparam int CFG_BITS = NUM_OUT * SEL_W
) (
  input  logic               cfgClk,
  input  logic               rstN,
  input  logic               shiftEn,
  input  logic               cfgIn,
  output logic               cfgOut,
  input  logic [NUM_IN-1:0]  routeIn,
  output logic [NUM_OUT-1:0] routeOut
);

  sm_pkg::scanStrobe_t scanStrobe;
  logic [CFG_BITS-1:0] selBus;

  assign scanStrobe.shift = shiftEn;
  assign scanStrobe.bitIn = cfgIn;

  sm_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
    .cfgClk  (cfgClk),
    .rstN    (rstN),
    .strobe  (scanStrobe),
    .cfgBits (selBus),
    .cfgOut  (cfgOut)
  );

  sm_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_route (
    .routeIn  (routeIn),
    .selBus   (selBus),
    .routeOut (routeOut)
  );

  // R6: outputs sharing a select carry the same wire
  a_r6_shared_source: assert property (@(posedge cfgClk) disable iff (!rstN)
    (selBus[SEL_W-1:0] == selBus[2*SEL_W-1:SEL_W]) |-> (routeOut[0] == routeOut[1]));

endmodule

// File: tb/sim_sm_switch_matrix.sv
module sim_sm_switch_matrix;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic shiftEn = 1'b0;
  logic cfgIn = 1'b0;
  logic cfgOut;
  logic [3:0] routeIn = 4'h0;
  logic [1:0] routeOut;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sm_switch_matrix u0 (
    .cfgClk(clk), .rstN(rstN), .shiftEn(shiftEn), .cfgIn(cfgIn),
    .cfgOut(cfgOut), .routeIn(routeIn), .routeOut(routeOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    shiftEn = 1'b1;
    cfgIn   = b;
    @(posedge clk);
  endtask

  // R5 order: b0=sel0[0], b1=sel0[1], b2=sel1[0], b3=sel1[1]
  task automatic loadSel(input logic [1:0] sel0, input logic [1:0] sel1);
    shiftBit(sel0[0]);
    shiftBit(sel0[1]);
    shiftBit(sel1[0]);
    shiftBit(sel1[1]);
    @(negedge clk);
    shiftEn = 1'b0;
  endtask

  task automatic checkRoute(input logic [1:0] s0, input logic [1:0] s1, input string tag);
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pat;
      pat = p[3:0];
      routeIn = pat;
      #1;
      check({tag, " out0"}, int'(routeOut[0]), int'(pat[s0]));
      check({tag, " out1"}, int'(routeOut[1]), int'(pat[s1]));
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 cfgOut after reset", int'(cfgOut), 0);
    checkRoute(2'd0, 2'd0, "R2 reset routing");
  endtask

  task automatic t_allSelects;
    for (int s = 0; s < 4; s++) begin
      loadSel(s[1:0], 2'(3 - s));
      checkRoute(s[1:0], 2'(3 - s), "R1 R5 select sweep");
    end
  endtask

  task automatic t_shared;
    loadSel(2'd2, 2'd2);
    checkRoute(2'd2, 2'd2, "R6 shared input");
    loadSel(2'd3, 2'd3);
    checkRoute(2'd3, 2'd3, "R6 shared input");
  endtask

  task automatic t_hold;
    loadSel(2'd1, 2'd3);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cfgIn = i[0];
    end
    @(negedge clk);
    checkRoute(2'd1, 2'd3, "R4 hold with shiftEn low");
  endtask

  task automatic t_comb;
    loadSel(2'd3, 2'd1);
    @(negedge clk);
    routeIn = 4'b1000;
    #1;
    check("R1 comb out0 rise", int'(routeOut[0]), 1);
    check("R1 comb out1 low", int'(routeOut[1]), 0);
    routeIn = 4'b0010;
    #1;
    check("R1 comb out0 fall", int'(routeOut[0]), 0);
    check("R1 comb out1 rise", int'(routeOut[1]), 1);
  endtask

  task automatic t_scanOut;
    logic [3:0] b;
    loadSel(2'd1, 2'd2);
    b = 4'b1001; // b0=1 b1=0 b2=0 b3=1
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 R3 cfgOut order", int'(cfgOut), int'(b[i]));
      shiftEn = 1'b1;
      cfgIn   = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    shiftEn = 1'b0;
    check("R3 chain flushed cfgOut", int'(cfgOut), 0);
    checkRoute(2'd0, 2'd0, "R3 chain flushed routing");
  endtask

  task automatic t_midReset;
    loadSel(2'd3, 2'd1);
    @(negedge clk);
    routeIn = 4'b1110;
    #1;
    check("R1 pre-reset out0", int'(routeOut[0]), 1);
    rstN = 1'b0;
    #1;
    check("R2 async clear out0", int'(routeOut[0]), 0);
    check("R2 async clear out1", int'(routeOut[1]), 0);
    check("R2 async clear cfgOut", int'(cfgOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    checkRoute(2'd0, 2'd0, "R2 after mid reset");
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_allSelects();
    t_shared();
    t_hold();
    t_comb();
    t_scanOut();
    t_midReset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule